// File: doc/BRIEF.md
# DMA channel control and interrupt register bank

This block is the shared register file that sits in front of a bank of DMA channels. Software reaches it through a simple word-wide bus with a write strobe, a byte address, write data and combinational read data. For each channel it holds a buffer address, two transfer lengths, a small control word and a line width, and drives them to the channel datapaths as flat output vectors.

Beside the per-channel registers it keeps four shared flag registers. The first latches one-cycle completion events from the channels until software clears them. The second enables interrupts per channel. The third holds a pair of loop bits per channel. The fourth is a write-only stop strobe. The enable and loop registers each have a separate clear address, so software can drop single bits without a read-modify-write. A single interrupt line is raised whenever a channel has both a pending event and its enable set.

Top module: `dma_ctl_bank`

## Requirements
- R1: After reset every register reads zero, and irq_o, ch_stop_o, ch_loop_o, ch_burst_o, ch_dir_o and all channel configuration outputs are zero.
- R2: Channel n has a buffer address at byte 0x10·n, a first length at 0x10·n+0x4 and a second length at 0x10·n+0x8. Each holds all 32 written bits, reads back, and drives its slice [32n+31:32n] of ch_addr_o, ch_xlen_o or ch_ylen_o.
- R3: Channel n's control word at 0x10·n+0xC keeps only bits [5:0] and reads zero above them. Bits [3:0] are the channel-number field, bit 4 drives ch_burst_o[n] and bit 5 drives ch_dir_o[n].
- R4: Channel n's line width at 0x100+4·n holds all 32 bits, reads back and drives ch_width_o[32n+31:32n].
- R5: Writing a 1 to bit n at 0x140 makes ch_stop_o[n] high for exactly the cycle after the write. Bits written 0 have no effect, and reads of 0x140 return zero.
- R6: The status register at 0x144 bit n is set in the cycle after ch_evt_i[n] is high. Writing a 1 to bit n clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear of the same bit leaves the bit set.
- R7: A write to 0x148 replaces the enable bits. Writing 1s to 0x14C clears the matching enable bits and leaves the rest unchanged. Reads of 0x14C return zero.
- R8: A write to 0x150 replaces the loop bits, bit n and bit n+16 for channel n. Writing 1s to 0x15C clears the matching loop bits. ch_loop_o[n] is high only while both bit n and bit n+16 are set. Reads of 0x15C return zero.
- R9: irq_o is high exactly when some channel has its status bit and its enable bit both set. It follows the registers in the same cycle.
- R10: Writes to addresses outside the map change nothing, and reads of them return zero. The low two address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr |
| ch_evt_i | input | NCH | One-cycle completion event per channel |
| irq_o | output | 1 | Combined interrupt |
| ch_stop_o | output | NCH | One-cycle stop strobe per channel |
| ch_loop_o | output | NCH | Loop mode active per channel |
| ch_burst_o | output | NCH | Burst mode bit per channel |
| ch_dir_o | output | NCH | Direction bit per channel |
| ch_addr_o | output | NCH*DW | Buffer addresses, channel n in slice n |
| ch_xlen_o | output | NCH*DW | First lengths |
| ch_ylen_o | output | NCH*DW | Second lengths |
| ch_width_o | output | NCH*DW | Line widths |

## Verification
A channel event and a software write-one-to-clear of the same status bit can arrive in one cycle. By rule the event must win, so the pending flag survives. The bench provokes this on purpose with a directed cycle that raises the event and clears the same bit together, then reads the status back. It also provokes it at random, by sending sparse random events while it writes random masks to the status address. A behavioural model applies the set after the clear and is compared with the read data and the interrupt line on every clock.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
   localparam logic [31:0] OFF_WIDTH   = 32'h100;
   localparam logic [31:0] OFF_STOP    = 32'h140;
   localparam logic [31:0] OFF_STS     = 32'h144;
   localparam logic [31:0] OFF_EN      = 32'h148;
   localparam logic [31:0] OFF_ENCLR   = 32'h14C;
   localparam logic [31:0] OFF_LOOP    = 32'h150;
   localparam logic [31:0] OFF_LOOPCLR = 32'h15C;
   localparam int CH_STRIDE = 16;
   localparam int LOOP_HI   = 16;
   localparam int BURST_BIT = 4;
   localparam int DIR_BIT   = 5;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_CHAN, SEL_WIDTH, SEL_STOP, SEL_STS,
      SEL_EN, SEL_ENCLR, SEL_LOOP, SEL_LOOPCLR
   } sel_e;

   typedef enum logic [1:0] {
      FLD_ADDR, FLD_XLEN, FLD_YLEN, FLD_CTRL
   } fld_e;
endpackage

// File: rtl/dmab_decode.sv
module dmab_decode
   import dmab_pkg::*;
#(
   parameter int NCH = 16,
   parameter int AW  = 12,
   parameter int CHW = 4
) (
   input  logic [AW-1:0]  addr,
   output sel_e           sel,
   output logic [CHW-1:0] ch,
   output fld_e           fld
);
   localparam logic [31:0] CHAN_END  = 32'(NCH * CH_STRIDE);
   localparam logic [31:0] WIDTH_END = OFF_WIDTH + 32'(4 * NCH);

   logic [31:0] wa;
   assign wa = 32'(addr) & 32'hFFFF_FFFC;

   always_comb begin
      sel = SEL_NONE;
      ch  = '0;
      fld = fld_e'(wa[3:2]);
      if (wa < CHAN_END) begin
         sel = SEL_CHAN;
         ch  = wa[4 +: CHW];
      end else if (wa >= OFF_WIDTH && wa < WIDTH_END) begin
         sel = SEL_WIDTH;
         ch  = wa[2 +: CHW];
      end else begin
         case (wa)
            OFF_STOP:    sel = SEL_STOP;
            OFF_STS:     sel = SEL_STS;
            OFF_EN:      sel = SEL_EN;
            OFF_ENCLR:   sel = SEL_ENCLR;
            OFF_LOOP:    sel = SEL_LOOP;
            OFF_LOOPCLR: sel = SEL_LOOPCLR;
            default:     sel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/dmab_chan_regs.sv
module dmab_chan_regs
   import dmab_pkg::*;
#(
   parameter int DW     = 32,
   parameter int CTRL_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              sel_cfg,
   input  logic              sel_width,
   input  fld_e              fld,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     addr_q,
   output logic [DW-1:0]     xlen_q,
   output logic [DW-1:0]     ylen_q,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [DW-1:0]     width_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         xlen_q  <= '0;
         ylen_q  <= '0;
         ctrl_q  <= '0;
         width_q <= '0;
      end else if (we) begin
         if (sel_width) width_q <= wdata;
         if (sel_cfg) begin
            case (fld)
               FLD_ADDR: addr_q <= wdata;
               FLD_XLEN: xlen_q <= wdata;
               FLD_YLEN: ylen_q <= wdata;
               default:  ctrl_q <= wdata[CTRL_W-1:0];
            endcase
         end
      end
   end
endmodule

// File: rtl/dmab_flag_bank.sv
module dmab_flag_bank
   import dmab_pkg::*;
#(
   parameter int NCH      = 16,
   parameter int DW       = 32,
   parameter bit IRQ_FLOP = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  sel_e           sel,
   input  logic [DW-1:0]  wdata,
   input  logic [NCH-1:0] evt,
   output logic [NCH-1:0] sts_q,
   output logic [NCH-1:0] en_q,
   output logic [NCH-1:0] lo_q,
   output logic [NCH-1:0] hi_q,
   output logic [NCH-1:0] stop_q,
   output logic [NCH-1:0] loop_act,
   output logic           irq
);
   logic [NCH-1:0] w_lo, w_hi, sts_clr;
   logic wr_sts, wr_en, wr_enclr, wr_loop, wr_loopclr, wr_stop;

   assign w_lo       = wdata[NCH-1:0];
   assign w_hi       = wdata[LOOP_HI +: NCH];
   assign wr_sts     = we && (sel == SEL_STS);
   assign wr_en      = we && (sel == SEL_EN);
   assign wr_enclr   = we && (sel == SEL_ENCLR);
   assign wr_loop    = we && (sel == SEL_LOOP);
   assign wr_loopclr = we && (sel == SEL_LOOPCLR);
   assign wr_stop    = we && (sel == SEL_STOP);
   assign sts_clr    = wr_sts ? w_lo : {NCH{1'b0}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q  <= '0;
         en_q   <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         stop_q <= '0;
      end else begin
         sts_q  <= (sts_q & ~sts_clr) | evt;
         stop_q <= wr_stop ? w_lo : {NCH{1'b0}};
         if (wr_en)         en_q <= w_lo;
         else if (wr_enclr) en_q <= en_q & ~w_lo;
         if (wr_loop) begin
            lo_q <= w_lo;
            hi_q <= w_hi;
         end else if (wr_loopclr) begin
            lo_q <= lo_q & ~w_lo;
            hi_q <= hi_q & ~w_hi;
         end
      end
   end

   assign loop_act = lo_q & hi_q;

   generate
      if (IRQ_FLOP) begin : g_irq_reg
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= |(sts_q & en_q);
         end
      end else begin : g_irq_comb
         assign irq = |(sts_q & en_q);
      end
   endgenerate
endmodule

// File: rtl/dma_ctl_bank.sv
module dma_ctl_bank
   import dmab_pkg::*;
#(
   parameter int NCH      = 16,
   parameter int DW       = 32,
   parameter int AW       = 12,
   parameter int CTRL_W   = 6,
   parameter bit IRQ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NCH-1:0]    ch_evt_i,
   output logic              irq_o,
   output logic [NCH-1:0]    ch_stop_o,
   output logic [NCH-1:0]    ch_loop_o,
   output logic [NCH-1:0]    ch_burst_o,
   output logic [NCH-1:0]    ch_dir_o,
   output logic [NCH*DW-1:0] ch_addr_o,
   output logic [NCH*DW-1:0] ch_xlen_o,
   output logic [NCH*DW-1:0] ch_ylen_o,
   output logic [NCH*DW-1:0] ch_width_o
);
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (NCH < 1 || NCH > LOOP_HI) begin : g_bad_nch
         $error("NCH must lie in 1..16");
      end
      if (DW < 32) begin : g_bad_dw
         $error("DW must be at least 32");
      end
      if (AW < 9) begin : g_bad_aw
         $error("AW must reach the flag registers");
      end
      if (CTRL_W < DIR_BIT + 1) begin : g_bad_ctrl
         $error("CTRL_W must hold the direction bit");
      end
   endgenerate

   sel_e           dec_sel;
   logic [CHW-1:0] dec_ch;
   fld_e           dec_fld;

   logic [DW-1:0]     r_addr  [NCH];
   logic [DW-1:0]     r_xlen  [NCH];
   logic [DW-1:0]     r_ylen  [NCH];
   logic [CTRL_W-1:0] r_ctrl  [NCH];
   logic [DW-1:0]     r_width [NCH];

   logic [NCH-1:0] sts_w, en_w, lo_w, hi_w;

   dmab_decode #(.NCH(NCH), .AW(AW), .CHW(CHW)) u_dec (
      .addr (bus_addr),
      .sel  (dec_sel),
      .ch   (dec_ch),
      .fld  (dec_fld)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic hit;
         assign hit = (dec_ch == CHW'(i));
         dmab_chan_regs #(.DW(DW), .CTRL_W(CTRL_W)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (bus_we && hit),
            .sel_cfg   (dec_sel == SEL_CHAN),
            .sel_width (dec_sel == SEL_WIDTH),
            .fld       (dec_fld),
            .wdata     (bus_wdata),
            .addr_q    (r_addr[i]),
            .xlen_q    (r_xlen[i]),
            .ylen_q    (r_ylen[i]),
            .ctrl_q    (r_ctrl[i]),
            .width_q   (r_width[i])
         );
         assign ch_addr_o[i*DW +: DW]  = r_addr[i];
         assign ch_xlen_o[i*DW +: DW]  = r_xlen[i];
         assign ch_ylen_o[i*DW +: DW]  = r_ylen[i];
         assign ch_width_o[i*DW +: DW] = r_width[i];
         assign ch_burst_o[i]          = r_ctrl[i][BURST_BIT];
         assign ch_dir_o[i]            = r_ctrl[i][DIR_BIT];
      end
   endgenerate

   dmab_flag_bank #(.NCH(NCH), .DW(DW), .IRQ_FLOP(IRQ_FLOP)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_we),
      .sel      (dec_sel),
      .wdata    (bus_wdata),
      .evt      (ch_evt_i),
      .sts_q    (sts_w),
      .en_q     (en_w),
      .lo_q     (lo_w),
      .hi_q     (hi_w),
      .stop_q   (ch_stop_o),
      .loop_act (ch_loop_o),
      .irq      (irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      case (dec_sel)
         SEL_CHAN: begin
            case (dec_fld)
               FLD_ADDR: bus_rdata = r_addr[dec_ch];
               FLD_XLEN: bus_rdata = r_xlen[dec_ch];
               FLD_YLEN: bus_rdata = r_ylen[dec_ch];
               default:  bus_rdata = DW'(r_ctrl[dec_ch]);
            endcase
         end
         SEL_WIDTH: bus_rdata = r_width[dec_ch];
         SEL_STS:   bus_rdata = DW'(sts_w);
         SEL_EN:    bus_rdata = DW'(en_w);
         SEL_LOOP: begin
            bus_rdata[NCH-1:0]       = lo_w;
            bus_rdata[LOOP_HI +: NCH] = hi_w;
         end
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_ctl_bank_chk.sv
module dma_ctl_bank_chk
   import dmab_pkg::*;
#(
   parameter int NCH = 16,
   parameter int DW  = 32,
   parameter int AW  = 12
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_we,
   input logic [AW-1:0]  bus_addr,
   input logic [DW-1:0]  bus_wdata,
   input logic [DW-1:0]  bus_rdata,
   input logic [NCH-1:0] evt,
   input logic [NCH-1:0] sts,
   input logic [NCH-1:0] en,
   input logic [NCH-1:0] loop_o,
   input logic [NCH-1:0] stop_o,
   input logic           irq_o
);
   logic [31:0]    wa;
   logic [NCH-1:0] w_lo, w_hi;
   assign wa   = 32'(bus_addr) & 32'hFFFF_FFFC;
   assign w_lo = bus_wdata[NCH-1:0];
   assign w_hi = bus_wdata[LOOP_HI +: NCH];

   assert_evt_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((sts & $past(evt)) == $past(evt)));

   assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && wa == OFF_STS) |=> ((sts & $past(w_lo & ~evt)) == '0));

   assert_en_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && wa == OFF_ENCLR) |=> ((en & $past(w_lo)) == '0));

   assert_alias_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wa == OFF_ENCLR || wa == OFF_LOOPCLR) |-> (bus_rdata == '0));

   assert_loop_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && wa == OFF_LOOPCLR) |=> ((loop_o & $past(w_lo | w_hi)) == '0));

   assert_stop_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_o != '0) |-> ($past(bus_we) && $past(wa) == OFF_STOP));

   assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0 && $past(en) == '0) |-> !irq_o);
endmodule

bind dma_ctl_bank dma_ctl_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .evt       (ch_evt_i),
   .sts       (sts_w),
   .en        (en_w),
   .loop_o    (ch_loop_o),
   .stop_o    (ch_stop_o),
   .irq_o     (irq_o)
);

// File: tb/tb_dma_ctl_bank.sv
module tb_dma_ctl_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] ch_evt_i = '0;
   logic irq_o;
   logic [NCH-1:0] ch_stop_o, ch_loop_o, ch_burst_o, ch_dir_o;
   logic [NCH*32-1:0] ch_addr_o, ch_xlen_o, ch_ylen_o, ch_width_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_ctl_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_evt_i(ch_evt_i),
      .irq_o(irq_o), .ch_stop_o(ch_stop_o), .ch_loop_o(ch_loop_o),
      .ch_burst_o(ch_burst_o), .ch_dir_o(ch_dir_o), .ch_addr_o(ch_addr_o),
      .ch_xlen_o(ch_xlen_o), .ch_ylen_o(ch_ylen_o), .ch_width_o(ch_width_o)
   );

   // behavioural reference state
   logic [31:0] m_addr [NCH];
   logic [31:0] m_x    [NCH];
   logic [31:0] m_y    [NCH];
   logic [31:0] m_w    [NCH];
   logic [5:0]  m_ctrl [NCH];
   logic [15:0] m_sts, m_en, m_lo, m_hi, m_stop;

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   task automatic check(input string req, input string what,
                        input logic [511:0] act, input logic [511:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [11:0] a);
      int wa;
      wa = int'(a) & ~3;
      if (wa < 16 * NCH) begin
         case ((wa >> 2) % 4)
            0: return m_addr[wa / 16];
            1: return m_x[wa / 16];
            2: return m_y[wa / 16];
            default: return {26'd0, m_ctrl[wa / 16]};
         endcase
      end
      if (wa >= 'h100 && wa < 'h100 + 4 * NCH) return m_w[(wa - 'h100) / 4];
      if (wa == 'h144) return {16'd0, m_sts};
      if (wa == 'h148) return {16'd0, m_en};
      if (wa == 'h150) return {m_hi, m_lo};
      return 32'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_addr[i] = '0; m_x[i] = '0; m_y[i] = '0; m_w[i] = '0; m_ctrl[i] = '0;
         end
         m_sts = '0; m_en = '0; m_lo = '0; m_hi = '0; m_stop = '0;
      end else begin
         int wa;
         wa = int'(bus_addr) & ~3;
         m_stop = (bus_we && wa == 'h140) ? bus_wdata[15:0] : 16'd0;
         if (bus_we && wa == 'h144) m_sts = m_sts & ~bus_wdata[15:0];
         m_sts = m_sts | ch_evt_i;   // set after clear: the event wins
         if (bus_we) begin
            if (wa == 'h148) m_en = bus_wdata[15:0];
            if (wa == 'h14C) m_en = m_en & ~bus_wdata[15:0];
            if (wa == 'h150) begin m_lo = bus_wdata[15:0]; m_hi = bus_wdata[31:16]; end
            if (wa == 'h15C) begin
               m_lo = m_lo & ~bus_wdata[15:0];
               m_hi = m_hi & ~bus_wdata[31:16];
            end
            if (wa < 16 * NCH) begin
               case ((wa >> 2) % 4)
                  0: m_addr[wa / 16] = bus_wdata;
                  1: m_x[wa / 16] = bus_wdata;
                  2: m_y[wa / 16] = bus_wdata;
                  default: m_ctrl[wa / 16] = bus_wdata[5:0];
               endcase
            end
            if (wa >= 'h100 && wa < 'h100 + 4 * NCH) m_w[(wa - 'h100) / 4] = bus_wdata;
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NCH*32-1:0] ea, ex, ey, ew;
         logic [NCH-1:0] eb, ed;
         for (int i = 0; i < NCH; i++) begin
            ea[i*32 +: 32] = m_addr[i];
            ex[i*32 +: 32] = m_x[i];
            ey[i*32 +: 32] = m_y[i];
            ew[i*32 +: 32] = m_w[i];
            eb[i] = m_ctrl[i][4];
            ed[i] = m_ctrl[i][5];
         end
         check(cur_req, "rdata", 512'(bus_rdata), 512'(m_read(bus_addr)));
         check("R9", "irq", 512'(irq_o), 512'(|(m_sts & m_en)));
         check("R5", "stop", 512'(ch_stop_o), 512'(m_stop));
         check("R8", "loop", 512'(ch_loop_o), 512'(m_lo & m_hi));
         check("R3", "burst/dir", 512'({eb, ed}), 512'({ch_burst_o, ch_dir_o}));
         check("R2", "addr/xlen/ylen", {ch_addr_o, ch_xlen_o, ch_ylen_o}, {ea, ex, ey});
         check("R4", "width", 512'(ch_width_o), 512'(ew));
      end
   end

   task automatic cyc(input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic [15:0] e);
      @(negedge clk);
      #1;
      bus_we = w; bus_addr = a; bus_wdata = d; ch_evt_i = e;
      @(posedge clk);
      #1;
      bus_we = 1'b0; ch_evt_i = '0;
   endtask

   task automatic rd_exp(input string req, input logic [11:0] a, input logic [31:0] exp);
      cyc(1'b0, a, 32'd0, 16'd0);
      @(negedge clk);
      check(req, $sformatf("read %0h", a), 512'(bus_rdata), 512'(exp));
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      cur_req = "R1";
      rd_exp("R1", 12'h000, 32'd0);
      rd_exp("R1", 12'h144, 32'd0);
      rd_exp("R1", 12'h150, 32'd0);
      check("R1", "irq", 512'(irq_o), 512'(0));
      check("R1", "width", 512'(ch_width_o), 512'(0));

      // R2 channel address and lengths
      cur_req = "R2";
      cyc(1, 12'h000, 32'h1234_5678, 0);
      cyc(1, 12'h054, 32'hCAFE_0042, 0);
      cyc(1, 12'h0F8, 32'h8000_0001, 0);
      rd_exp("R2", 12'h000, 32'h1234_5678);
      rd_exp("R2", 12'h054, 32'hCAFE_0042);
      rd_exp("R2", 12'h0FA, 32'h8000_0001);
      check("R2", "ch5 xlen", 512'(ch_xlen_o[5*32 +: 32]), 512'(32'hCAFE_0042));

      // R3 control word
      cur_req = "R3";
      cyc(1, 12'h03C, 32'hFFFF_FF3A, 0);
      cyc(1, 12'h07C, 32'h0000_0025, 0);
      rd_exp("R3", 12'h03C, 32'h0000_003A);
      check("R3", "ch3 burst", 512'(ch_burst_o[3]), 512'(1));
      check("R3", "ch7 burst/dir", 512'({ch_burst_o[7], ch_dir_o[7]}), 512'(2'b01));

      // R4 widths
      cur_req = "R4";
      cyc(1, 12'h124, 32'h0000_0040, 0);
      cyc(1, 12'h13C, 32'hDEAD_BEEF, 0);
      rd_exp("R4", 12'h124, 32'h0000_0040);
      rd_exp("R4", 12'h13C, 32'hDEAD_BEEF);

      // R5 stop strobe
      cur_req = "R5";
      cyc(1, 12'h140, 32'h0000_8001, 0);
      @(negedge clk);
      check("R5", "stop pulse", 512'(ch_stop_o), 512'(16'h8001));
      @(negedge clk);
      check("R5", "stop after", 512'(ch_stop_o), 512'(0));
      rd_exp("R5", 12'h140, 32'd0);

      // R6 status, including set and clear in one cycle
      cur_req = "R6";
      cyc(0, 12'h144, 0, 16'h0004);
      rd_exp("R6", 12'h144, 32'h4);
      cyc(1, 12'h144, 32'h0, 0);
      rd_exp("R6", 12'h144, 32'h4);
      cyc(1, 12'h144, 32'h4, 16'h0004);
      rd_exp("R6", 12'h144, 32'h4);
      cyc(1, 12'h144, 32'h4, 0);
      rd_exp("R6", 12'h144, 32'h0);

      // R7 enable and its clear alias
      cur_req = "R7";
      cyc(1, 12'h148, 32'h0000_FFFF, 0);
      cyc(1, 12'h14C, 32'h0000_00F0, 0);
      rd_exp("R7", 12'h148, 32'h0000_FF0F);
      rd_exp("R7", 12'h14C, 32'h0);

      // R8 loop pairs and their clear alias
      cur_req = "R8";
      cyc(1, 12'h150, 32'h0003_0005, 0);
      @(negedge clk);
      check("R8", "loop pair", 512'(ch_loop_o), 512'(16'h0001));
      rd_exp("R8", 12'h150, 32'h0003_0005);
      cyc(1, 12'h15C, 32'h0001_0000, 0);
      rd_exp("R8", 12'h150, 32'h0002_0005);
      check("R8", "loop cleared", 512'(ch_loop_o), 512'(0));
      rd_exp("R8", 12'h15C, 32'h0);

      // R9 interrupt combine
      cur_req = "R9";
      cyc(0, 12'h144, 0, 16'h0020);
      @(negedge clk);
      check("R9", "masked irq", 512'(irq_o), 512'(0));
      cyc(1, 12'h148, 32'h0000_0020, 0);
      @(negedge clk);
      check("R9", "enabled irq", 512'(irq_o), 512'(1));
      cyc(1, 12'h144, 32'h0000_0020, 0);
      @(negedge clk);
      check("R9", "cleared irq", 512'(irq_o), 512'(0));

      // R10 unmapped space
      cur_req = "R10";
      cyc(1, 12'h160, 32'hFFFF_FFFF, 0);
      cyc(1, 12'h400, 32'hFFFF_FFFF, 0);
      rd_exp("R10", 12'h160, 32'h0);
      rd_exp("R10", 12'h400, 32'h0);
      rd_exp("R10", 12'h148, 32'h0000_0020);

      // random traffic against the model
      cur_req = "R6";
      for (int k = 0; k < 600; k++) begin
         logic [11:0] a;
         int pick;
         pick = int'($urandom % 6);
         case (pick)
            0: a = 12'($urandom % 256);
            1: a = 12'h100 + 12'($urandom % 64);
            2: a = 12'h144;
            3: a = 12'h140 + 12'(4 * ($urandom % 8));
            4: a = 12'h15C;
            default: a = 12'($urandom % 1024);
         endcase
         cyc(1'($urandom % 2), a, $urandom,
             16'($urandom & $urandom & $urandom));
      end

      repeat (2) @(negedge clk);
      finish_up();
   end
endmodule